// File: doc/BRIEF.md
# PRBS Loopback Link Tester

This block exercises a four-lane serial link that is looped back outside the chip. It sits on the parallel side of the transceivers. After reset, every lane sends a fixed synchronization word, which lets the receive path find word boundaries and bond the lanes. When a start command arrives, each lane switches to its own pseudo-random sequence on the polynomial x^31 + x^28 + 1, at one full word per clock. On the receive side, each lane's checker takes its seed from the data coming back. It predicts the next word from the one before it, and counts unbroken runs of correct predictions.

Five status outputs follow the link through its stages:
- PLL lock.
- Pattern synchronized: the comma-detect and bond enables are on, and every lane reports aligned and bonded.
- PRBS data received, which also marks the test as complete.
- Data error, which is sticky.
- A heartbeat.

Asserting the bond and start commands in the same cycle deliberately flips one transmitted bit. This shows that the error path works.

Top module: `lbt_link_tester`

## Requirements
- R1: After reset, all status outputs, the heartbeat and both enable outputs are low, and every lane transmits the synchronization word.
- R2: Until PRBS mode has started, every lane transmits the synchronization word, 32'h3CBC3CBC by default.
- R3: Take a start pulse sampled alone at clock edge k. The word after edge k is still the synchronization word. From edge k+1 on, lane i sends F(SEED_BASE+i) and then F(previous word[30:0]) on each clock. F runs 32 steps of b = s[30]^s[27], s = {s[29:0], b}, and emits the first bit at bit 31. SEED_BASE defaults to 31'h1ACE0001. Lane i occupies tx bits [32i+31:32i].
- R4: A comma pulse sets the comma-detect enable. A bond pulse that arrives without start sets the bond enable. Both stay set until reset.
- R5: The sync status is registered. It is high one clock after both enables are on and every lane's aligned and bonded flags are high, and it drops one clock after any of these falls.
- R6: The lock status equals the PLL-lock input one clock earlier.
- R7: In PRBS mode, data-received sets once every lane has had 16 consecutive words that each equal F of the previous word's low 31 bits. An all-zero word never counts as a match. The flag stays set until reset.
- R8: Once data-received is set, any lane word that fails the prediction sets the error status, which stays set until reset.
- R9: Bond and start asserted in the same cycle while in PRBS mode invert bit 0 of the next lane-0 word only. This happens once per rising edge of the combined command. The combined command never acts as a bond or start command, and outside PRBS mode it has no effect.
- R10: The heartbeat output inverts every 2^(HB_LOG2-1) clocks.
- R11: A reset in the middle of a test clears error, data-received, sync and both enables, and returns every lane to the synchronization word.
- R12: After data-received, breaking a lane's loopback so that a constant word returns sets the error status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel-side clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pll_lock_i | input | 1 | PLL lock indication |
| cmd_comma_i | input | 1 | Pulse: enable comma detection |
| cmd_bond_i | input | 1 | Pulse: enable channel bonding |
| cmd_start_i | input | 1 | Pulse: start PRBS transmission |
| lane_aligned_i | input | LANES | Per-lane word-aligned flags |
| lane_bonded_i | input | LANES | Per-lane bonded flags |
| rx_data_i | input | LANES*W | Received words, lane i at [W*i+W-1:W*i] |
| tx_data_o | output | LANES*W | Transmitted words, lane i at [W*i+W-1:W*i] |
| comma_en_o | output | 1 | Comma-detect enable level |
| bond_en_o | output | 1 | Channel-bond enable level |
| stat_lock_o | output | 1 | Lock status |
| stat_sync_o | output | 1 | Pattern-synchronized status |
| stat_rx_o | output | 1 | PRBS received / test complete |
| stat_err_o | output | 1 | Sticky data error |
| heartbeat_o | output | 1 | Activity indicator |

## Verification
The assertions check, on every cycle, the following:
- The error and data-received flags stay set once raised.
- An error never appears before data-received.
- Data-received never appears outside PRBS mode.
- Sync status never appears without both enables.
- An idle transmitter sends only the synchronization word.
- A lane's run completes only on a matching word.

Only the bench scenarios can show the rest:
- The exact PRBS word sequence per lane.
- The edge at which each status changes.
- That a single injected bit flips only lane 0 and is then caught through the loopback.
- That an all-zero lane blocks completion.
- That a mid-test reset clears everything.

// File: rtl/lbt_pkg.sv
package lbt_pkg;

   // Advance a 31-bit x^31+x^28+1 register by nbits steps.
   // The first produced bit lands at position nbits-1.
   function automatic logic [63:0] prbs_adv(input logic [30:0] seed,
                                            input int unsigned nbits);
      logic [30:0] s;
      logic [63:0] r;
      logic        b;
      s = seed;
      r = '0;
      for (int unsigned k = 0; k < 64; k++) begin
         if (k < nbits) begin
            b = s[30] ^ s[27];
            s = {s[29:0], b};
            r = {r[62:0], b};
         end
      end
      return r;
   endfunction

endpackage

// File: rtl/lbt_prbs_tx.sv
module lbt_prbs_tx #(
   parameter int unsigned    W       = 32,
   parameter logic [30:0]    SEED    = 31'h1ACE0001,
   parameter logic [W-1:0]   SYNC    = W'(32'h3CBC3CBC),
   parameter int unsigned    INJ_BIT = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run_i,
   input  logic         inj_i,
   output logic [W-1:0] tx_o
);
   import lbt_pkg::*;

   localparam logic [W-1:0] FLIP = W'(1) << INJ_BIT;

   logic [30:0]  st_q;
   logic [W-1:0] nxt;

   assign nxt = W'(prbs_adv(st_q, W));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= SEED;
         tx_o <= SYNC;
      end else if (run_i) begin
         st_q <= nxt[30:0];
         tx_o <= inj_i ? (nxt ^ FLIP) : nxt;
      end else begin
         tx_o <= SYNC;
      end
   end

   AST_SYNC_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> (tx_o == SYNC)); // R2

endmodule

// File: rtl/lbt_prbs_chk.sv
module lbt_prbs_chk #(
   parameter int unsigned W        = 32,
   parameter int unsigned LOCK_RUN = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] rx_i,
   output logic         hit_o,
   output logic         ok_o
);
   import lbt_pkg::*;

   localparam int unsigned CW = $clog2(LOCK_RUN + 1);
   localparam logic [CW-1:0] RUN_MAX = CW'(LOCK_RUN);

   logic [30:0]   prev_q;
   logic [CW-1:0] run_q;
   logic [W-1:0]  pred;

   // Prediction seeded from the previous received word.
   assign pred  = W'(prbs_adv(prev_q, W));
   assign hit_o = (rx_i == pred) && (rx_i != '0);
   assign ok_o  = (run_q >= RUN_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         run_q  <= '0;
      end else begin
         prev_q <= rx_i[30:0];
         if (!hit_o)
            run_q <= '0;
         else if (run_q != RUN_MAX)
            run_q <= run_q + CW'(1);
      end
   end

   AST_OK_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ok_o) |-> $past(hit_o)); // R7

endmodule

// File: rtl/lbt_heartbeat.sv
module lbt_heartbeat #(
   parameter int unsigned LOG2 = 24
) (
   input  logic clk,
   input  logic rst_n,
   output logic hb_o
);
   logic [LOG2-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_q + LOG2'(1);
   end

   assign hb_o = cnt_q[LOG2-1];

endmodule

// File: rtl/lbt_link_tester.sv
module lbt_link_tester #(
   parameter int unsigned  LANES     = 4,
   parameter int unsigned  W         = 32,
   parameter int unsigned  LOCK_RUN  = 16,
   parameter int unsigned  HB_LOG2   = 24,
   parameter logic [30:0]  SEED_BASE = 31'h1ACE0001,
   parameter logic [W-1:0] SYNC_WORD = W'(32'h3CBC3CBC),
   parameter int unsigned  INJ_BIT   = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pll_lock_i,
   input  logic               cmd_comma_i,
   input  logic               cmd_bond_i,
   input  logic               cmd_start_i,
   input  logic [LANES-1:0]   lane_aligned_i,
   input  logic [LANES-1:0]   lane_bonded_i,
   input  logic [LANES*W-1:0] rx_data_i,
   output logic [LANES*W-1:0] tx_data_o,
   output logic               comma_en_o,
   output logic               bond_en_o,
   output logic               stat_lock_o,
   output logic               stat_sync_o,
   output logic               stat_rx_o,
   output logic               stat_err_o,
   output logic               heartbeat_o
);

   localparam longint unsigned SEED_TOP = longint'(SEED_BASE) + LANES - 1;

   generate
      if (LANES < 1 || W < 31 || W > 64)
         $error("lbt_link_tester: LANES must be >=1 and W in 31..64");
      if (LOCK_RUN < 1 || HB_LOG2 < 1 || INJ_BIT >= W)
         $error("lbt_link_tester: bad LOCK_RUN, HB_LOG2 or INJ_BIT");
      if (SEED_BASE == 31'd0 || SEED_TOP > 64'h7FFF_FFFF)
         $error("lbt_link_tester: lane seeds must be nonzero and distinct");
   endgenerate

   logic             prbs_mode;
   logic             combo, combo_q, inj;
   logic [LANES-1:0] lane_hit, lane_ok;

   assign combo = cmd_bond_i & cmd_start_i;
   assign inj   = combo & ~combo_q & prbs_mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         combo_q     <= 1'b0;
         prbs_mode   <= 1'b0;
         comma_en_o  <= 1'b0;
         bond_en_o   <= 1'b0;
         stat_lock_o <= 1'b0;
         stat_sync_o <= 1'b0;
         stat_rx_o   <= 1'b0;
         stat_err_o  <= 1'b0;
      end else begin
         combo_q     <= combo;
         prbs_mode   <= prbs_mode  | (cmd_start_i & ~cmd_bond_i);
         comma_en_o  <= comma_en_o | cmd_comma_i;
         bond_en_o   <= bond_en_o  | (cmd_bond_i & ~cmd_start_i);
         stat_lock_o <= pll_lock_i;
         stat_sync_o <= comma_en_o & bond_en_o
                        & (&lane_aligned_i) & (&lane_bonded_i);
         stat_rx_o   <= stat_rx_o  | (prbs_mode & (&lane_ok));
         stat_err_o  <= stat_err_o | (stat_rx_o & ~(&lane_hit));
      end
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      lbt_prbs_tx #(
         .W       (W),
         .SEED    (31'(SEED_BASE + i)),
         .SYNC    (SYNC_WORD),
         .INJ_BIT (INJ_BIT)
      ) u_tx (
         .clk   (clk),
         .rst_n (rst_n),
         .run_i (prbs_mode),
         .inj_i ((i == 0) ? inj : 1'b0),
         .tx_o  (tx_data_o[W*i +: W])
      );

      lbt_prbs_chk #(
         .W        (W),
         .LOCK_RUN (LOCK_RUN)
      ) u_chk (
         .clk   (clk),
         .rst_n (rst_n),
         .rx_i  (rx_data_i[W*i +: W]),
         .hit_o (lane_hit[i]),
         .ok_o  (lane_ok[i])
      );
   end

   lbt_heartbeat #(.LOG2(HB_LOG2)) u_hb (
      .clk   (clk),
      .rst_n (rst_n),
      .hb_o  (heartbeat_o)
   );

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      stat_err_o |=> stat_err_o); // R8
   AST_ERR_AFTER_RX: assert property (@(posedge clk) disable iff (!rst_n)
      stat_err_o |-> stat_rx_o); // R8
   AST_RX_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      stat_rx_o |=> stat_rx_o); // R7
   AST_RX_NEEDS_PRBS: assert property (@(posedge clk) disable iff (!rst_n)
      stat_rx_o |-> prbs_mode); // R7
   AST_SYNC_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      stat_sync_o |-> (comma_en_o && bond_en_o)); // R5

endmodule

// File: tb/tb_lbt_link_tester.sv
module tb_lbt_link_tester;
   localparam int CLK_PERIOD = 10;
   localparam int LANES = 4;
   localparam int W = 32;
   localparam logic [31:0] SYNC = 32'h3CBC3CBC;
   localparam logic [30:0] SEED = 31'h1ACE0001;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pll_lock = 1'b0, c_comma = 1'b0, c_bond = 1'b0, c_start = 1'b0;
   logic [LANES-1:0] aligned = '0, bonded = '0;
   logic [LANES*W-1:0] rx, tx;
   logic comma_en, bond_en, s_lock, s_sync, s_rx, s_err, hb;
   logic [LANES-1:0] brk = '0;
   logic [W-1:0] brk_val = '0;
   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   always_comb begin
      for (int i = 0; i < LANES; i++)
         rx[W*i +: W] = brk[i] ? brk_val : tx[W*i +: W];
   end

   lbt_link_tester #(.HB_LOG2(3)) dut (
      .clk(clk), .rst_n(rst_n), .pll_lock_i(pll_lock),
      .cmd_comma_i(c_comma), .cmd_bond_i(c_bond), .cmd_start_i(c_start),
      .lane_aligned_i(aligned), .lane_bonded_i(bonded), .rx_data_i(rx),
      .tx_data_o(tx), .comma_en_o(comma_en), .bond_en_o(bond_en),
      .stat_lock_o(s_lock), .stat_sync_o(s_sync), .stat_rx_o(s_rx),
      .stat_err_o(s_err), .heartbeat_o(hb));

   // Next word from a 31-bit state, via the recurrence b[n] = b[n-31] ^ b[n-28].
   function automatic logic [31:0] nextw(input logic [30:0] s);
      logic b [0:62];
      logic [31:0] w;
      for (int j = 0; j < 31; j++) b[j] = s[30-j];
      for (int j = 31; j < 63; j++) begin
         b[j] = b[j-31] ^ b[j-28];
         w[62-j] = b[j];
      end
      return w;
   endfunction

   function automatic logic [31:0] lane(input int i);
      return tx[W*i +: W];
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse(input logic cm, input logic bd, input logic st);
      c_comma = cm; c_bond = bd; c_start = st;
      @(negedge clk);
      c_comma = 0; c_bond = 0; c_start = 0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0;
      step(2);
      rst_n = 1;
   endtask

   task automatic t_reset_state();
      do_reset();
      chk(!s_lock && !s_sync && !s_rx && !s_err && !hb, "R1 status", {s_lock,s_sync,s_rx,s_err,hb}, 0);
      chk(!comma_en && !bond_en, "R1 enables", {comma_en,bond_en}, 0);
      for (int i = 0; i < LANES; i++) chk(lane(i) == SYNC, "R1 tx sync", lane(i), SYNC);
   endtask

   task automatic t_lock();
      pll_lock = 1; step(1);
      chk(s_lock == 1, "R6 lock rise", s_lock, 1);
      pll_lock = 0; step(1);
      chk(s_lock == 0, "R6 lock fall", s_lock, 0);
      pll_lock = 1;
   endtask

   task automatic t_sync();
      aligned = '1; bonded = '1;
      pulse(1, 0, 0);
      chk(comma_en == 1, "R4 comma enable", comma_en, 1);
      chk(s_sync == 0, "R5 sync waits for bond", s_sync, 0);
      pulse(0, 1, 0);
      chk(bond_en == 1, "R4 bond enable", bond_en, 1);
      step(1);
      chk(s_sync == 1, "R5 sync set", s_sync, 1);
      aligned[1] = 0; step(1);
      chk(s_sync == 0, "R5 sync drop", s_sync, 0);
      aligned[1] = 1; step(1);
      chk(s_sync == 1, "R5 sync back", s_sync, 1);
   endtask

   task automatic t_inj_idle();
      pulse(0, 1, 1);
      step(3);
      for (int i = 0; i < LANES; i++) chk(lane(i) == SYNC, "R9 combined ignored outside prbs", lane(i), SYNC);
      chk(s_err == 0, "R9 no error", s_err, 0);
      chk(s_rx == 0, "R2 no prbs yet", s_rx, 0);
   endtask

   task automatic t_start();
      logic [31:0] prev [LANES];
      pulse(0, 0, 1);
      for (int i = 0; i < LANES; i++) chk(lane(i) == SYNC, "R2 sync until next edge", lane(i), SYNC);
      step(1);
      for (int i = 0; i < LANES; i++) begin
         chk(lane(i) == nextw(31'(SEED + i)), "R3 first prbs word", lane(i), nextw(31'(SEED + i)));
         prev[i] = lane(i);
      end
      step(1);
      for (int i = 0; i < LANES; i++)
         chk(lane(i) == nextw(prev[i][30:0]), "R3 prbs chain", lane(i), nextw(prev[i][30:0]));
      step(8);
      chk(s_rx == 0, "R7 rx not yet", s_rx, 0);
      step(15);
      chk(s_rx == 1, "R7 rx complete", s_rx, 1);
      step(50);
      chk(s_err == 0, "R8 clean loopback no error", s_err, 0);
   endtask

   task automatic t_inject();
      logic [31:0] p0, p1;
      p0 = lane(0); p1 = lane(1);
      pulse(0, 1, 1);
      chk(lane(0) == (nextw(p0[30:0]) ^ 32'h1), "R9 lane0 flipped", lane(0), nextw(p0[30:0]) ^ 32'h1);
      chk(lane(1) == nextw(p1[30:0]), "R9 lane1 untouched", lane(1), nextw(p1[30:0]));
      step(3);
      chk(s_err == 1, "R8 error raised", s_err, 1);
      step(20);
      chk(s_err == 1, "R8 error sticky", s_err, 1);
   endtask

   task automatic t_mid_reset();
      do_reset();
      chk(!s_err && !s_rx && !s_sync, "R11 status cleared", {s_err,s_rx,s_sync}, 0);
      chk(!comma_en && !bond_en, "R11 enables cleared", {comma_en,bond_en}, 0);
      step(2);
      for (int i = 0; i < LANES; i++) chk(lane(i) == SYNC, "R11 tx back to sync", lane(i), SYNC);
   endtask

   task automatic t_break();
      brk = 4'b1000; brk_val = '0;
      pulse(1, 0, 0); pulse(0, 1, 0); pulse(0, 0, 1);
      step(40);
      chk(s_rx == 0, "R7 zero lane never matches", s_rx, 0);
      brk = '0; step(30);
      chk(s_rx == 1, "R7 rx after release", s_rx, 1);
      chk(s_err == 0, "R8 no error before break", s_err, 0);
      brk = 4'b0100; brk_val = 32'h0;
      step(3);
      chk(s_err == 1, "R12 broken loopback error", s_err, 1);
      brk = '0;
   endtask

   task automatic t_heartbeat();
      logic h0;
      h0 = hb; step(4);
      chk(hb == ~h0, "R10 heartbeat toggles", hb, ~h0);
      step(4);
      chk(hb == h0, "R10 heartbeat toggles back", hb, h0);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      t_reset_state();
      t_lock();
      t_sync();
      t_inj_idle();
      t_start();
      t_inject();
      t_mid_reset();
      t_break();
      t_heartbeat();
      done = 1;
      finish_run();
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog all requirements actual=timeout expected=completion");
         finish_run();
      end
   end
endmodule